// File: doc/BRIEF.md
# Read-Valid Latency Generator

This block sits between a memory controller and the read side of a physical-layer interface. Every time the controller issues a read, it raises a read-issued flag. The block returns a read-data-valid flag a fixed number of controller clock cycles later. That number is the read latency found during calibration. The block also reports this latency back to the controller, so the controller can plan its own pipelines.

The controller runs at half the memory rate, so each controller cycle holds two memory-rate slots. The read-issued input and the valid output are therefore two bits wide, one bit per slot:

- Bit 0 is the first half of the cycle.
- Bit 1 is the second half of the cycle.

Each output bit copies its own input bit after the delay, so a read that starts in the second half also lands in the second half.

The latency setting is taken once, on the first cycle in which calibration-done is seen high. From then on it stays fixed until the next reset. While calibration has not finished, the outputs stay quiet.

Top module: `rd_valid_delay`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after, `rd_valid` is 0 and `lat_report` is 0.
- R2: While the block is unlocked (no calibration-done seen since reset), `rd_valid` stays 0 and `lat_report` stays 0, whatever `rd_req` does.
- R3: Once locked with an effective latency N, bit k of `rd_valid` is high in cycle c+N exactly when bit k of `rd_req` was high in cycle c. This holds for every cycle c in which `lat_report` was already nonzero. Bit 0 is the first half-cycle slot and bit 1 is the second.
- R4: The lock happens at the first rising edge that samples `cal_done` high. From the next cycle on, `lat_report` shows N, and requests made in that cycle and later are delayed per R3.
- R5: N is `lat_cfg` limited to the range 1 to MAX_LAT: a setting of 0 gives N = 1, and a setting above MAX_LAT gives N = MAX_LAT.
- R6: After lock, changes on `lat_cfg` and deassertion of `cal_done` have no effect on `lat_report` or on the delay until the next reset.
- R7: A request on every slot of every cycle produces valid on every slot, N cycles later, with no gaps and no lost pulses.
- R8: A reset discards every request still in flight. After a new lock, no valid appears that comes from a request made before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 2 | Read-issued flags, bit 0 is the first half-cycle slot and bit 1 the second |
| lat_cfg | input | LAT_W | Calibrated latency, in controller cycles |
| cal_done | input | 1 | Calibration finished successfully |
| rd_valid | output | 2 | Read-data-valid flags, aligned slot for slot with `rd_req` |
| lat_report | output | LAT_W | Locked latency, or 0 before lock |

## Verification
The block's internal state has three parts: the ring write pointer, the fill counter and the locked latency. A fault in any of them shows at `rd_valid` as a pulse that is early, late, missing, or swapped between slots. If a stale memory word is read, a phantom pulse appears in the first N cycles after a lock. These faults surface within N cycles of the affected request. A fault in the lock logic shows at once, on `lat_report`, in the cycle after `cal_done` is sampled or after a later change on `lat_cfg`. For this reason the outputs are compared with a reference model on every cycle, across several latencies including both clamp limits.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

  typedef enum logic {
    LK_IDLE = 1'b0,
    LK_RUN  = 1'b1
  } lock_state_t;

  // Limit a raw latency setting to the supported range [1, max_lat].
  function automatic int clamp_lat(input int raw, input int max_lat);
    if (raw < 1)       return 1;
    if (raw > max_lat) return max_lat;
    return raw;
  endfunction

endpackage

// File: rtl/rvd_lock.sv
module rvd_lock
  import rvd_pkg::*;
#(
  parameter int MAX_LAT = 32,
  parameter int LAT_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_done,
  input  logic [LAT_W-1:0] lat_cfg,
  output logic             locked,
  output logic [LAT_W-1:0] lat_q
);

  lock_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= LK_IDLE;
      lat_q <= '0;
    end else if (st_q == LK_IDLE && cal_done) begin
      st_q  <= LK_RUN;
      lat_q <= LAT_W'(clamp_lat(int'(lat_cfg), MAX_LAT));
    end
  end

  assign locked = (st_q == LK_RUN);

endmodule

// File: rtl/rvd_fill.sv
module rvd_fill #(
  parameter int MAX_LAT = 32,
  parameter int LAT_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             locked,
  input  logic [LAT_W-1:0] lat_q,
  output logic             primed
);

  localparam logic [LAT_W-1:0] FILL_TOP = LAT_W'(MAX_LAT);

  logic [LAT_W-1:0] fill_q;

  // Counts ring writes made since lock; saturates once it covers the deepest tap.
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (locked && fill_q != FILL_TOP) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  // The tap N-1 entries back holds post-lock data once that many writes happened.
  assign primed = (fill_q >= (lat_q - 1'b1));

endmodule

// File: rtl/rvd_ring.sv
module rvd_ring #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);

  logic mem [DEPTH];

  // Plain write port, no reset: maps onto distributed RAM.
  always_ff @(posedge clk) begin
    mem[wr_addr] <= wr_bit;
  end

  assign rd_bit = mem[rd_addr];

endmodule

// File: rtl/rd_valid_delay.sv
module rd_valid_delay #(
  parameter int LANES   = 2,
  parameter int MAX_LAT = 32,
  parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] rd_req,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic             cal_done,
  output logic [LANES-1:0] rd_valid,
  output logic [LAT_W-1:0] lat_report
);

  localparam int AW    = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;
  localparam int DEPTH = 1 << AW;

  logic             locked;
  logic [LAT_W-1:0] lat_q;
  logic             primed;
  logic [AW-1:0]    wp_q;
  logic [AW-1:0]    rp;
  logic [LAT_W-1:0] back;
  logic [LANES-1:0] wr_data;
  logic [LANES-1:0] tap;
  logic [LANES-1:0] valid_q;

  rvd_lock #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .cal_done (cal_done),
    .lat_cfg  (lat_cfg),
    .locked   (locked),
    .lat_q    (lat_q)
  );

  rvd_fill #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_fill (
    .clk    (clk),
    .rst    (rst),
    .locked (locked),
    .lat_q  (lat_q),
    .primed (primed)
  );

  // Requests count only once the lock is in place.
  assign wr_data = rd_req & {LANES{locked}};

  always_ff @(posedge clk) begin
    if (rst) wp_q <= '0;
    else     wp_q <= wp_q + 1'b1;
  end

  // Read tap sits N-1 writes behind; the output register supplies the last cycle.
  assign back = lat_q - 1'b1;
  assign rp   = wp_q - AW'(back);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      rvd_ring #(.DEPTH(DEPTH), .AW(AW)) u_ring (
        .clk     (clk),
        .wr_addr (wp_q),
        .wr_bit  (wr_data[g]),
        .rd_addr (rp),
        .rd_bit  (tap[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !locked)   valid_q <= '0;
    else if (lat_q == 1)  valid_q <= rd_req;
    else if (primed)      valid_q <= tap;
    else                  valid_q <= '0;
  end

  assign rd_valid   = valid_q;
  assign lat_report = lat_q;

endmodule

// File: rtl/rd_valid_delay_chk.sv
module rd_valid_delay_chk #(
  parameter int LANES   = 2,
  parameter int MAX_LAT = 32,
  parameter int LAT_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] rd_req,
  input logic [LANES-1:0] rd_valid,
  input logic [LAT_W-1:0] lat_report
);

  // Request history seen at the ports, gated by the lock shown on lat_report.
  logic [LANES-1:0] hist [MAX_LAT];
  logic [LANES-1:0] hist_tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAX_LAT; i++) hist[i] <= '0;
    end else begin
      hist[0] <= (lat_report != '0) ? rd_req : '0;
      for (int i = 1; i < MAX_LAT; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    hist_tap = '0;
    for (int i = 0; i < MAX_LAT; i++)
      if (int'(lat_report) == i + 1) hist_tap = hist[i];
  end

  // R2: unlocked block stays quiet
  a_r2_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
    (lat_report == '0) |-> (rd_valid == '0));

  // R3: valid equals the request N cycles back, slot by slot
  a_r3_exact_delay: assert property (@(posedge clk) disable iff (rst)
    (lat_report != '0) |-> (rd_valid == hist_tap));

  // R5: reported latency never exceeds the supported maximum
  a_r5_in_range: assert property (@(posedge clk) disable iff (rst)
    (lat_report <= LAT_W'(MAX_LAT)));

  // R6: once nonzero, the report is frozen
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (lat_report != '0) |=> $stable(lat_report));

endmodule

bind rd_valid_delay rd_valid_delay_chk #(
  .LANES(LANES), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .lat_report (lat_report)
);

// File: tb/sim_rd_valid_delay.sv
module sim_rd_valid_delay;

  localparam int LANES   = 2;
  localparam int MAX_LAT = 32;
  localparam int LAT_W   = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LANES-1:0] rd_req = '0;
  logic [LAT_W-1:0] lat_cfg = '0;
  logic             cal_done = 1'b0;
  logic [LANES-1:0] rd_valid;
  logic [LAT_W-1:0] lat_report;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // Reference model state
  bit               m_locked = 0;
  int               m_lat = 0;
  logic [LANES-1:0] m_hist[$];

  always #2 clk = ~clk;

  rd_valid_delay #(.LANES(LANES), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst(rst), .rd_req(rd_req), .lat_cfg(lat_cfg),
    .cal_done(cal_done), .rd_valid(rd_valid), .lat_report(lat_report)
  );

  function automatic int clamp(input int raw);
    if (raw < 1) return 1;
    if (raw > MAX_LAT) return MAX_LAT;
    return raw;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_locked = 0;
      m_lat = 0;
      m_hist.delete();
    end else begin
      m_hist.push_front(m_locked ? rd_req : '0);
      if (m_hist.size() > MAX_LAT + 4) void'(m_hist.pop_back());
      if (!m_locked && cal_done) begin
        m_locked = 1;
        m_lat = clamp(int'(lat_cfg));
      end
    end
    started = 1;
  end

  function automatic logic [LANES-1:0] exp_valid();
    if (!m_locked || m_hist.size() < m_lat) return '0;
    return m_hist[m_lat-1];
  endfunction

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison, sampled at the falling edge.
  always @(negedge clk) begin
    if (started && !finished) begin
      check_eq(cur_tag, "rd_valid", int'(rd_valid), int'(exp_valid()));
      check_eq(cur_tag, "lat_report", int'(lat_report), m_lat);
    end
  end

  task automatic drive(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      case (mode)
        0: rd_req = LANES'($urandom_range(0, 3));
        1: rd_req = '1;
        2: rd_req = (i % 2 == 0) ? 2'b01 : 2'b10;
        default: rd_req = '0;
      endcase
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge clk); #1;
    rst = 1'b1; cal_done = 1'b0;
    drive(n, 0);
    @(negedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic lock_at(input int cfg);
    @(negedge clk); #1;
    lat_cfg = LAT_W'(cfg);
    cal_done = 1'b1;
    rd_req = LANES'($urandom_range(0, 3));
  endtask

  task automatic lat_scenario(input string tag, input int cfg, input int want);
    cur_tag = "R1";
    do_reset(3);
    @(negedge clk);
    check_eq("R1", "rd_valid after reset", int'(rd_valid), 0);
    check_eq("R1", "lat_report after reset", int'(lat_report), 0);
    cur_tag = tag;
    lock_at(cfg);
    @(negedge clk);
    check_eq(tag, "lat_report after lock", int'(lat_report), want);
    drive(want + 10, 1);
    drive(want + 30, 0);
    drive(want + 2, 3);
  endtask

  initial begin
    drive(4, 0);
    @(negedge clk);
    check_eq("R1", "rd_valid in reset", int'(rd_valid), 0);
    check_eq("R1", "lat_report in reset", int'(lat_report), 0);
    @(negedge clk); #1;
    rst = 1'b0;

    // R2: unlocked, requests ignored
    cur_tag = "R2";
    drive(20, 0);
    drive(10, 1);

    // R4 / R3: lock at 5 and run random traffic
    cur_tag = "R4";
    lock_at(5);
    @(negedge clk);
    check_eq("R4", "lat_report after lock", int'(lat_report), 5);
    cur_tag = "R3";
    drive(60, 0);

    // R6: later changes ignored
    cur_tag = "R6";
    @(negedge clk); #1;
    lat_cfg = 6'd9; cal_done = 1'b0;
    drive(20, 0);
    check_eq("R6", "lat_report after cfg change", int'(lat_report), 5);

    // R7: full occupancy and alternating slots
    cur_tag = "R7";
    drive(40, 1);
    drive(30, 2);

    // R8: reset with requests in flight, relock at 1
    cur_tag = "R8";
    drive(3, 1);
    do_reset(2);
    drive(5, 1);
    lock_at(1);
    drive(40, 0);

    // R5: clamp limits and other latencies
    lat_scenario("R5", 0, 1);
    lat_scenario("R5", 45, MAX_LAT);
    lat_scenario("R3", 32, 32);
    lat_scenario("R3", 2, 2);
    lat_scenario("R7", 7, 7);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule